// File: doc/BRIEF.md
# User-Level Interrupt Channel Unit

This unit lets a simple in-order core take interrupts at user level, raised by cache-line invalidations that arrive on the coherence snoop path. Software arms a channel with two values: a memory address to watch and the entry address of a user handler. When an invalidation lands on the cache line of an armed channel, that channel is marked pending and disarms itself. A two-state sequencer then delivers the interrupt. It redirects the fetch program counter to the channel's handler and keeps the interrupted PC in one save register. A return command sends fetch back to that saved PC.

The sequencer has two states. In `ST_IDLE` no handler is running. In `ST_HANDLER` a handler is active. The deliver transition (`ST_IDLE` to `ST_HANDLER`) is taken when any channel is pending. It emits a one-cycle redirect to the handler of the lowest-numbered pending channel and clears that channel's pending bit. The resume transition (`ST_HANDLER` to `ST_IDLE`) is taken on a return command and emits a one-cycle redirect to the saved PC. Hits that arrive while a handler runs stay pending and are delivered one after another once the handler returns.

The unit also forwards work-signal commands, each carrying a routine pointer and a data pointer, to a thread spawner. It does this through a request register with a valid/ready handshake.

Top module: `uli_channel_unit`

## Requirements
- R1: After reset no channel is armed and nothing is pending. `redirect_valid`, `spawn_valid`, `in_handler` and `arm_busy` are 0, and `sig_ready` is 1.
- R2: An arm command stores its watch address and handler in the lowest-indexed channel that is neither armed nor pending.
- R3: A snoop hits a channel when bits [ADDR_W-1:6] of the snoop address equal those of the watch address. The low 6 bits are ignored, and any difference in the upper bits is a miss.
- R4: A channel disarms when it fires. A later invalidation of the same line gives no redirect until the channel is armed again.
- R5: A hit sampled at clock edge k while the unit is idle gives `redirect_valid` = 1 for one cycle after edge k+1, with `redirect_pc` equal to the channel's handler. `in_handler` becomes 1 at that same edge.
- R6: At delivery the value of `cur_pc` is saved. A return command while `in_handler` is 1 gives, after the next edge, a one-cycle redirect to the saved PC, and `in_handler` falls to 0.
- R7: Hits taken while a handler runs are held pending. After each return, the lowest-indexed pending channel is delivered one edge after the resume redirect.
- R8: A return command while no handler is running and nothing is pending causes no redirect.
- R9: A signal command raises `spawn_valid` after the next edge, carrying the routine and data pointers. The request holds them unchanged until a cycle with `spawn_ready` = 1, after which `spawn_valid` drops.
- R10: An arm command that finds every channel armed or pending pulses `arm_busy` for one cycle after the next edge. It changes no channel.
- R11: `sig_ready` is 0 while a spawn request is outstanding, and a signal command given then is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_valid | input | 1 | Arm command strobe |
| arm_watch_addr | input | ADDR_W | Address to watch |
| arm_handler | input | ADDR_W | User handler entry address |
| arm_busy | output | 1 | Pulse: previous arm found no free channel |
| snoop_valid | input | 1 | Invalidation observed on the coherence path |
| snoop_addr | input | ADDR_W | Invalidated address |
| ret_valid | input | 1 | Return-from-handler command |
| cur_pc | input | ADDR_W | PC of the code running when a delivery happens |
| redirect_valid | output | 1 | Fetch redirect strobe |
| redirect_pc | output | ADDR_W | Fetch redirect target |
| in_handler | output | 1 | A user handler is active |
| sig_valid | input | 1 | Signal command strobe |
| sig_routine | input | ADDR_W | Worker routine pointer |
| sig_data | input | ADDR_W | Worker data pointer |
| sig_ready | output | 1 | Signal command can be taken |
| spawn_valid | output | 1 | Spawn request valid |
| spawn_routine | output | ADDR_W | Spawn routine pointer |
| spawn_data | output | ADDR_W | Spawn data pointer |
| spawn_ready | input | 1 | Spawner accepts the request |

## Verification
Every output is registered, so the bench drives inputs and samples at falling edges. A snoop hit reaches `redirect_valid` two rising edges after it is driven. One edge records the pending bit and the second takes the deliver transition. A return, an arm reply on `arm_busy` and a spawn request each appear after a single edge. The scoreboard queues each expected redirect target before the stimulus is applied, and the monitor pops and compares on every falling edge where `redirect_valid` is high. Any redirect not on the queue is reported, so misses, disarmed channels and ignored returns are checked by the redirects that fail to appear.

// File: rtl/uli_pkg.sv
package uli_pkg;

    typedef enum logic [0:0] {
        ST_IDLE    = 1'b0,
        ST_HANDLER = 1'b1
    } uli_state_e;

endpackage

// File: rtl/uli_chan_bank.sv
module uli_chan_bank #(
    parameter int NUM_CH    = 4,
    parameter int ADDR_W    = 32,
    parameter int LINE_BITS = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_valid,
    input  logic [ADDR_W-1:0] arm_watch_addr,
    input  logic [ADDR_W-1:0] arm_handler,
    output logic              arm_busy,
    input  logic              snoop_valid,
    input  logic [ADDR_W-1:0] snoop_addr,
    input  logic              take,
    output logic              pend_any,
    output logic [ADDR_W-1:0] pend_handler
);

    localparam int TAG_W = ADDR_W - LINE_BITS;
    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic [NUM_CH-1:0] ch_armed;
    logic [NUM_CH-1:0] ch_pend;
    logic [TAG_W-1:0]  ch_tag     [NUM_CH];
    logic [ADDR_W-1:0] ch_handler [NUM_CH];

    logic [NUM_CH-1:0] hit;
    logic [NUM_CH-1:0] arm_sel;
    logic [NUM_CH-1:0] take_sel;
    logic              free_any;
    logic [IDX_W-1:0]  free_idx;
    logic [IDX_W-1:0]  pend_idx;

    // lowest free channel
    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (!ch_armed[i] && !ch_pend[i]) begin
                free_any = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    // lowest pending channel
    always_comb begin
        pend_any = 1'b0;
        pend_idx = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (ch_pend[i]) begin
                pend_any = 1'b1;
                pend_idx = IDX_W'(i);
            end
        end
    end

    assign pend_handler = ch_handler[pend_idx];

    genvar g;
    generate
        for (g = 0; g < NUM_CH; g++) begin : g_chan
            assign hit[g]      = snoop_valid && ch_armed[g] &&
                                 (snoop_addr[ADDR_W-1:LINE_BITS] == ch_tag[g]);
            assign arm_sel[g]  = arm_valid && free_any && (free_idx == IDX_W'(g));
            assign take_sel[g] = take && pend_any && (pend_idx == IDX_W'(g));

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ch_armed[g]   <= 1'b0;
                    ch_pend[g]    <= 1'b0;
                    ch_tag[g]     <= '0;
                    ch_handler[g] <= '0;
                end else begin
                    if (arm_sel[g]) begin
                        ch_armed[g]   <= 1'b1;
                        ch_tag[g]     <= arm_watch_addr[ADDR_W-1:LINE_BITS];
                        ch_handler[g] <= arm_handler;
                    end else if (hit[g]) begin
                        ch_armed[g] <= 1'b0;
                    end
                    if (hit[g]) begin
                        ch_pend[g] <= 1'b1;
                    end else if (take_sel[g]) begin
                        ch_pend[g] <= 1'b0;
                    end
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_busy <= 1'b0;
        end else begin
            arm_busy <= arm_valid && !free_any;
        end
    end

endmodule

// File: rtl/uli_seq.sv
module uli_seq
    import uli_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pend_any,
    input  logic [ADDR_W-1:0] pend_handler,
    input  logic              ret_valid,
    input  logic [ADDR_W-1:0] cur_pc,
    output logic              take,
    output logic              redirect_valid,
    output logic [ADDR_W-1:0] redirect_pc,
    output logic              in_handler,
    output logic [ADDR_W-1:0] save_pc
);

    uli_state_e state_q;
    uli_state_e state_d;
    logic       do_deliver;
    logic       do_resume;

    always_comb begin
        state_d    = state_q;
        do_deliver = 1'b0;
        do_resume  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (pend_any) begin
                    do_deliver = 1'b1;
                    state_d    = ST_HANDLER;
                end
            end
            ST_HANDLER: begin
                if (ret_valid) begin
                    do_resume = 1'b1;
                    state_d   = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign take       = do_deliver;
    assign in_handler = (state_q == ST_HANDLER);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redirect_valid <= 1'b0;
            redirect_pc    <= '0;
            save_pc        <= '0;
        end else begin
            redirect_valid <= do_deliver || do_resume;
            if (do_deliver) begin
                redirect_pc <= pend_handler;
                save_pc     <= cur_pc;
            end else if (do_resume) begin
                redirect_pc <= save_pc;
            end
        end
    end

endmodule

// File: rtl/uli_spawn_port.sv
module uli_spawn_port #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sig_valid,
    input  logic [ADDR_W-1:0] sig_routine,
    input  logic [ADDR_W-1:0] sig_data,
    output logic              sig_ready,
    output logic              spawn_valid,
    output logic [ADDR_W-1:0] spawn_routine,
    output logic [ADDR_W-1:0] spawn_data,
    input  logic              spawn_ready
);

    assign sig_ready = !spawn_valid;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spawn_valid   <= 1'b0;
            spawn_routine <= '0;
            spawn_data    <= '0;
        end else if (!spawn_valid) begin
            if (sig_valid) begin
                spawn_valid   <= 1'b1;
                spawn_routine <= sig_routine;
                spawn_data    <= sig_data;
            end
        end else if (spawn_ready) begin
            spawn_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/uli_channel_unit.sv
module uli_channel_unit #(
    parameter int NUM_CH    = 4,
    parameter int ADDR_W    = 32,
    parameter int LINE_BITS = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_valid,
    input  logic [ADDR_W-1:0] arm_watch_addr,
    input  logic [ADDR_W-1:0] arm_handler,
    output logic              arm_busy,
    input  logic              snoop_valid,
    input  logic [ADDR_W-1:0] snoop_addr,
    input  logic              ret_valid,
    input  logic [ADDR_W-1:0] cur_pc,
    output logic              redirect_valid,
    output logic [ADDR_W-1:0] redirect_pc,
    output logic              in_handler,
    input  logic              sig_valid,
    input  logic [ADDR_W-1:0] sig_routine,
    input  logic [ADDR_W-1:0] sig_data,
    output logic              sig_ready,
    output logic              spawn_valid,
    output logic [ADDR_W-1:0] spawn_routine,
    output logic [ADDR_W-1:0] spawn_data,
    input  logic              spawn_ready
);

    logic              pend_any;
    logic [ADDR_W-1:0] pend_handler;
    logic              take;
    logic [ADDR_W-1:0] save_pc;

    uli_chan_bank #(
        .NUM_CH    (NUM_CH),
        .ADDR_W    (ADDR_W),
        .LINE_BITS (LINE_BITS)
    ) u_bank (
        .clk            (clk),
        .rst_n          (rst_n),
        .arm_valid      (arm_valid),
        .arm_watch_addr (arm_watch_addr),
        .arm_handler    (arm_handler),
        .arm_busy       (arm_busy),
        .snoop_valid    (snoop_valid),
        .snoop_addr     (snoop_addr),
        .take           (take),
        .pend_any       (pend_any),
        .pend_handler   (pend_handler)
    );

    uli_seq #(
        .ADDR_W (ADDR_W)
    ) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .pend_any       (pend_any),
        .pend_handler   (pend_handler),
        .ret_valid      (ret_valid),
        .cur_pc         (cur_pc),
        .take           (take),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc),
        .in_handler     (in_handler),
        .save_pc        (save_pc)
    );

    uli_spawn_port #(
        .ADDR_W (ADDR_W)
    ) u_spawn (
        .clk           (clk),
        .rst_n         (rst_n),
        .sig_valid     (sig_valid),
        .sig_routine   (sig_routine),
        .sig_data      (sig_data),
        .sig_ready     (sig_ready),
        .spawn_valid   (spawn_valid),
        .spawn_routine (spawn_routine),
        .spawn_data    (spawn_data),
        .spawn_ready   (spawn_ready)
    );

endmodule

// File: rtl/uli_channel_unit_checker.sv
module uli_channel_unit_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              arm_valid,
    input logic              arm_busy,
    input logic              ret_valid,
    input logic [ADDR_W-1:0] cur_pc,
    input logic              redirect_valid,
    input logic [ADDR_W-1:0] redirect_pc,
    input logic              in_handler,
    input logic              pend_any,
    input logic [ADDR_W-1:0] save_pc,
    input logic              sig_ready,
    input logic              spawn_valid,
    input logic [ADDR_W-1:0] spawn_routine,
    input logic [ADDR_W-1:0] spawn_data,
    input logic              spawn_ready
);

    // R5: entering a handler comes with a fetch redirect
    p_enter_redirect_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_handler) |-> redirect_valid);

    // R6: the saved PC is the one presented at delivery
    p_save_pc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_handler) |-> save_pc == $past(cur_pc));

    // R6: leaving a handler redirects to the saved PC
    p_resume_pc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_handler) |-> (redirect_valid && redirect_pc == $past(save_pc)));

    // R8: a return with nothing running and nothing pending is ignored
    p_ret_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && !in_handler && !pend_any) |=> !redirect_valid);

    // R9: a stalled spawn request keeps its payload
    p_spawn_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (spawn_valid && !spawn_ready) |=>
            (spawn_valid && $stable(spawn_routine) && $stable(spawn_data)));

    // R10: busy only answers an arm command
    p_busy_reply_r10: assert property (@(posedge clk) disable iff (!rst_n)
        arm_busy |-> $past(arm_valid));

    // R11: no new signal command taken while a request is outstanding
    p_sig_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
        spawn_valid |-> !sig_ready);

endmodule

bind uli_channel_unit uli_channel_unit_checker #(
    .ADDR_W (ADDR_W)
) u_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .arm_valid      (arm_valid),
    .arm_busy       (arm_busy),
    .ret_valid      (ret_valid),
    .cur_pc         (cur_pc),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .in_handler     (in_handler),
    .pend_any       (pend_any),
    .save_pc        (save_pc),
    .sig_ready      (sig_ready),
    .spawn_valid    (spawn_valid),
    .spawn_routine  (spawn_routine),
    .spawn_data     (spawn_data),
    .spawn_ready    (spawn_ready)
);

// File: tb/uli_channel_unit_bench.sv
module uli_channel_unit_bench;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          arm_valid = 1'b0;
    logic [AW-1:0] arm_watch_addr = '0;
    logic [AW-1:0] arm_handler = '0;
    logic          arm_busy;
    logic          snoop_valid = 1'b0;
    logic [AW-1:0] snoop_addr = '0;
    logic          ret_valid = 1'b0;
    logic [AW-1:0] cur_pc = 32'h0000_1234;
    logic          redirect_valid;
    logic [AW-1:0] redirect_pc;
    logic          in_handler;
    logic          sig_valid = 1'b0;
    logic [AW-1:0] sig_routine = '0;
    logic [AW-1:0] sig_data = '0;
    logic          sig_ready;
    logic          spawn_valid;
    logic [AW-1:0] spawn_routine;
    logic [AW-1:0] spawn_data;
    logic          spawn_ready = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [AW-1:0] pc;
        string         tag;
    } exp_t;
    exp_t exp_q[$];

    always #2 clk = ~clk;

    uli_channel_unit u_uli_channel_unit (
        .clk            (clk),
        .rst_n          (rst_n),
        .arm_valid      (arm_valid),
        .arm_watch_addr (arm_watch_addr),
        .arm_handler    (arm_handler),
        .arm_busy       (arm_busy),
        .snoop_valid    (snoop_valid),
        .snoop_addr     (snoop_addr),
        .ret_valid      (ret_valid),
        .cur_pc         (cur_pc),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc),
        .in_handler     (in_handler),
        .sig_valid      (sig_valid),
        .sig_routine    (sig_routine),
        .sig_data       (sig_data),
        .sig_ready      (sig_ready),
        .spawn_valid    (spawn_valid),
        .spawn_routine  (spawn_routine),
        .spawn_data     (spawn_data),
        .spawn_ready    (spawn_ready)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic expect_redirect(input logic [AW-1:0] pc, input string tag);
        exp_t e;
        e.pc  = pc;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    // monitor: every redirect must match the head of the queue
    always @(negedge clk) begin
        if (rst_n && redirect_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "unexpected redirect (R3/R4/R8)", redirect_pc, '0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(redirect_pc == e.pc, e.tag, redirect_pc, e.pc);
            end
        end
    end

    task automatic arm(input logic [AW-1:0] w, input logic [AW-1:0] h,
                       output logic busy);
        @(negedge clk);
        arm_valid      = 1'b1;
        arm_watch_addr = w;
        arm_handler    = h;
        @(negedge clk);
        busy      = arm_busy;
        arm_valid = 1'b0;
    endtask

    task automatic snoop(input logic [AW-1:0] a);
        @(negedge clk);
        snoop_valid = 1'b1;
        snoop_addr  = a;
        @(negedge clk);
        snoop_valid = 1'b0;
    endtask

    task automatic ret();
        @(negedge clk);
        ret_valid = 1'b1;
        @(negedge clk);
        ret_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic b;
        logic [AW-1:0] P;
        P = 32'h0000_1234;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!redirect_valid, "R1 redirect_valid", AW'(redirect_valid), 0);
        check(!spawn_valid, "R1 spawn_valid", AW'(spawn_valid), 0);
        check(!in_handler, "R1 in_handler", AW'(in_handler), 0);
        check(!arm_busy, "R1 arm_busy", AW'(arm_busy), 0);
        check(sig_ready, "R1 sig_ready", AW'(sig_ready), 1);
        rst_n = 1'b1;
        idle(2);

        // R2 arm two channels (ch0, ch1)
        arm(32'h1000_0040, 32'h0000_A000, b);
        check(!b, "R2 arm accepted", AW'(b), 0);
        arm(32'h2000_0000, 32'h0000_B000, b);
        check(!b, "R2 arm accepted", AW'(b), 0);

        // R3 other line: no redirect
        snoop(32'h1000_0080);
        idle(4);
        check(!in_handler, "R3 miss keeps idle", AW'(in_handler), 0);

        // R3 R5 same line, different low bits
        expect_redirect(32'h0000_A000, "R5 deliver handler A");
        snoop(32'h1000_0045);
        idle(1);
        check(in_handler, "R5 in_handler set", AW'(in_handler), 1);

        // R6 return
        expect_redirect(P, "R6 resume saved PC");
        cur_pc = 32'h0000_9999;
        ret();
        idle(1);
        check(!in_handler, "R6 in_handler clear", AW'(in_handler), 0);
        cur_pc = P;

        // R4 disarmed channel does not fire again
        snoop(32'h1000_0040);
        idle(4);
        check(!in_handler, "R4 disarmed", AW'(in_handler), 0);

        // R8 return while idle
        ret();
        idle(3);
        check(!in_handler, "R8 idle return", AW'(in_handler), 0);

        // R7 ordering: ch0 free again (R2 lowest free), ch1 armed, ch2 new
        arm(32'h3000_0000, 32'h0000_C000, b);
        arm(32'h4000_0000, 32'h0000_D000, b);
        expect_redirect(32'h0000_B000, "R7 first handler B");
        snoop(32'h2000_0010);
        idle(2);
        snoop(32'h4000_0000);
        snoop(32'h3000_003F);
        idle(3);
        check(in_handler, "R7 still in handler B", AW'(in_handler), 1);
        expect_redirect(P, "R7 resume after B");
        expect_redirect(32'h0000_C000, "R7 lowest pending C");
        ret();
        idle(3);
        expect_redirect(P, "R7 resume after C");
        expect_redirect(32'h0000_D000, "R7 next pending D");
        ret();
        idle(3);
        expect_redirect(P, "R7 resume after D");
        ret();
        idle(3);
        check(exp_q.size() == 0, "R7 all redirects seen", AW'(exp_q.size()), 0);

        // R10 fill all four, fifth is busy
        arm(32'h5000_0000, 32'h0000_E000, b);
        check(!b, "R10 arm ch0", AW'(b), 0);
        arm(32'h5100_0000, 32'h0000_E100, b);
        arm(32'h5200_0000, 32'h0000_E200, b);
        arm(32'h5300_0000, 32'h0000_E300, b);
        check(!b, "R10 arm ch3", AW'(b), 0);
        arm(32'h5400_0000, 32'h0000_E400, b);
        check(b, "R10 busy on full", AW'(b), 1);
        idle(1);
        check(!arm_busy, "R10 busy one cycle", AW'(arm_busy), 0);
        snoop(32'h5400_0000);
        idle(4);
        check(!in_handler, "R10 rejected arm not stored", AW'(in_handler), 0);
        for (int i = 0; i < 4; i++) begin
            expect_redirect(32'h0000_E000 + AW'(i) * 32'h100, "R10 existing channel intact");
            snoop(32'h5000_0000 + AW'(i) * 32'h0100_0000);
            idle(1);
            expect_redirect(P, "R10 resume");
            ret();
            idle(2);
        end
        check(exp_q.size() == 0, "R10 all redirects seen", AW'(exp_q.size()), 0);

        // R9 R11 spawn handshake
        @(negedge clk);
        sig_valid   = 1'b1;
        sig_routine = 32'hCAFE_0000;
        sig_data    = 32'hDA7A_0000;
        @(negedge clk);
        sig_valid = 1'b0;
        check(spawn_valid, "R9 spawn_valid", AW'(spawn_valid), 1);
        check(spawn_routine == 32'hCAFE_0000, "R9 routine", spawn_routine, 32'hCAFE_0000);
        check(!sig_ready, "R11 sig_ready low", AW'(sig_ready), 0);
        @(negedge clk);
        sig_valid   = 1'b1;
        sig_routine = 32'h1111_1111;
        sig_data    = 32'h2222_2222;
        @(negedge clk);
        sig_valid = 1'b0;
        idle(3);
        check(spawn_valid, "R9 held", AW'(spawn_valid), 1);
        check(spawn_routine == 32'hCAFE_0000, "R11 ignored routine", spawn_routine, 32'hCAFE_0000);
        check(spawn_data == 32'hDA7A_0000, "R9 data stable", spawn_data, 32'hDA7A_0000);
        spawn_ready = 1'b1;
        @(negedge clk);
        spawn_ready = 1'b0;
        check(!spawn_valid, "R9 drop after accept", AW'(spawn_valid), 0);
        idle(3);
        check(!spawn_valid, "R11 no second request", AW'(spawn_valid), 0);

        idle(2);
        check(exp_q.size() == 0, "scoreboard drained", AW'(exp_q.size()), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule